// File: doc/BRIEF.md
# Four-Bit Bidirectional Arithmetic Shifter

This block moves a 4-bit operand left or right by zero to three places in a single combinational pass. It has no clock and no reset. A one-bit direction input picks the direction. A two-bit amount code is turned into a one-hot select inside the block. Operand and result number their bits from the most significant end: index 0 is the MSB, and index 3 is the LSB.

Left shifts fill the freed low-order places with zeros. Right shifts are arithmetic: every freed high-order place takes a copy of the operand's original MSB. Only one shifting network exists, and it shifts left. A right shift reverses the bit order of the operand, passes it through that left network, reverses the result back, and then overwrites the freed places with the sign bit.

Top module: `shf_bidir_unit`

## Requirements
- R1: With an amount code of 0, the result equals the operand for both directions.
- R2: For a left shift by n, result bit k equals operand bit k+n whenever k+n is at most 3, where bit 0 is the MSB.
- R3: For a left shift by n, result bits 4-n through 3 (the low-order end) are 0.
- R4: For a right shift by n, result bit k equals operand bit k-n whenever k is at least n.
- R5: For a right shift by n, result bits 0 through n-1 all equal operand bit 0, the original MSB.
- R6: A direction input of 1 gives a left shift and 0 gives a right shift, for the same operand and amount.
- R7: The result follows any change of the inputs without a clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 4 | Operand; index 0 is the MSB |
| dir_i | input | 1 | 1 = shift left, 0 = arithmetic shift right |
| amt_i | input | 2 | Shift distance, 0 to 3 |
| res_o | output | 4 | Shifted result; index 0 is the MSB |

## Verification
The hardest case to reach from the ports is a right shift where the reversed left network and the sign-fill overlay both act on the same result. The fill has to replace exactly the n places the network left at zero. Bits next to that boundary must come from the reversed path, not from the fill. Negative operands with mixed low bits, such as 1011 and 1001, shifted right by every amount, put a sign copy and a data bit side by side at that boundary. A sweep over every operand, direction and amount then compares the whole result against an arithmetic model and checks the filled places on their own.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int SHF_WIDTH = 4;

    typedef enum logic {
        SHF_RIGHT = 1'b0,
        SHF_LEFT  = 1'b1
    } shf_dir_e;
endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode #(
    parameter int W  = 4,
    parameter int AW = 2
) (
    input  logic [AW-1:0] amt_i,
    output logic [0:W-1]  sel_o
);
    always_comb begin
        sel_o = '0;
        for (int i = 0; i < W; i++) begin
            if (int'(amt_i) == i) sel_o[i] = 1'b1;
        end
    end

    always_comb begin
        p_sel_onehot_r1: assert ($onehot(sel_o))
            else $error("one-hot select violated");
    end
endmodule

// File: rtl/shf_left_core.sv
module shf_left_core #(
    parameter int W = 4
) (
    input  logic [0:W-1] x_i,
    input  logic [0:W-1] sel_i,
    output logic [0:W-1] z_o
);
    logic [0:W-1] term [0:W-1];

    for (genvar k = 0; k < W; k++) begin : g_bit
        for (genvar i = 0; i < W; i++) begin : g_amt
            if (k + i < W) begin : g_src
                assign term[k][i] = sel_i[i] & x_i[k+i];
            end else begin : g_zero
                assign term[k][i] = 1'b0;
            end
        end
        assign z_o[k] = |term[k];
    end

    always_comb begin
        if (sel_i[0]) begin
            p_core_pass_r1: assert (z_o == x_i)
                else $error("core zero-shift mismatch");
        end
        if (sel_i[W-1]) begin
            p_core_max_r2: assert (z_o[0] == x_i[W-1])
                else $error("core max-shift mismatch");
        end
    end
endmodule

// File: rtl/shf_sign_fill.sv
module shf_sign_fill #(
    parameter int W = 4
) (
    input  logic [0:W-1] sel_i,
    input  logic [0:W-1] raw_i,
    input  logic         sign_i,
    output logic [0:W-1] y_o
);
    logic [0:W-1] hit [0:W-1];
    logic [0:W-1] mask;

    for (genvar k = 0; k < W; k++) begin : g_pos
        for (genvar i = 0; i < W; i++) begin : g_amt
            if (k < i) begin : g_on
                assign hit[k][i] = sel_i[i];
            end else begin : g_off
                assign hit[k][i] = 1'b0;
            end
        end
        assign mask[k] = |hit[k];
        assign y_o[k]  = mask[k] ? sign_i : raw_i[k];
    end

    always_comb begin
        if (!sel_i[0]) begin
            p_fill_msb_r5: assert (y_o[0] == sign_i)
                else $error("sign fill missing at MSB");
        end
    end
endmodule

// File: rtl/shf_bidir_unit.sv
module shf_bidir_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = SHF_WIDTH,
    localparam int AW   = $clog2(WIDTH)
) (
    input  logic [0:WIDTH-1] opnd_i,
    input  logic             dir_i,
    input  logic [AW-1:0]    amt_i,
    output logic [0:WIDTH-1] res_o
);
    shf_dir_e         dir;
    logic [0:WIDTH-1] sel;
    logic [0:WIDTH-1] opnd_rev;
    logic [0:WIDTH-1] core_in;
    logic [0:WIDTH-1] core_out;
    logic [0:WIDTH-1] core_rev;
    logic [0:WIDTH-1] right_res;

    assign dir = shf_dir_e'(dir_i);

    shf_amt_decode #(.W(WIDTH), .AW(AW)) u_dec (
        .amt_i (amt_i),
        .sel_o (sel)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign opnd_rev[k] = opnd_i[WIDTH-1-k];
        assign core_rev[k] = core_out[WIDTH-1-k];
    end

    assign core_in = (dir == SHF_LEFT) ? opnd_i : opnd_rev;

    shf_left_core #(.W(WIDTH)) u_core (
        .x_i   (core_in),
        .sel_i (sel),
        .z_o   (core_out)
    );

    shf_sign_fill #(.W(WIDTH)) u_fill (
        .sel_i  (sel),
        .raw_i  (core_rev),
        .sign_i (opnd_i[0]),
        .y_o    (right_res)
    );

    assign res_o = (dir == SHF_LEFT) ? core_out : right_res;

    always_comb begin
        if (dir == SHF_LEFT) begin
            p_left_head_r2: assert (res_o[0] == opnd_i[amt_i])
                else $error("left shift head bit wrong");
            if (amt_i != '0) begin
                p_left_zero_r3: assert (res_o[WIDTH-1] == 1'b0)
                    else $error("left shift LSB not zero");
            end
        end else begin
            p_right_sign_r5: assert (res_o[0] == opnd_i[0])
                else $error("right shift lost sign");
            p_right_tail_r4: assert (res_o[amt_i] == opnd_i[0])
                else $error("right shift tail wrong");
        end
    end
endmodule

// File: tb/sim_shf_bidir_unit.sv
module sim_shf_bidir_unit;
    logic       clk = 1'b0;
    logic [0:3] opnd;
    logic       dir;
    logic [1:0] amt;
    logic [0:3] res;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #10 clk = ~clk;

    shf_bidir_unit u0 (
        .opnd_i (opnd),
        .dir_i  (dir),
        .amt_i  (amt),
        .res_o  (res)
    );

    // {dir, amt, operand, expected}; leftmost written bit is index 0 (MSB)
    localparam logic [10:0] VEC [0:11] = '{
        {1'b1, 2'd1, 4'b1011, 4'b0110},  // R2 R3
        {1'b1, 2'd2, 4'b1011, 4'b1100},  // R2 R3
        {1'b1, 2'd3, 4'b1011, 4'b1000},  // R2 R3
        {1'b0, 2'd1, 4'b1011, 4'b1101},  // R4 R5
        {1'b0, 2'd2, 4'b1011, 4'b1110},  // R4 R5
        {1'b0, 2'd3, 4'b1011, 4'b1111},  // R5
        {1'b0, 2'd1, 4'b0110, 4'b0011},  // R4 R5 positive
        {1'b0, 2'd3, 4'b0110, 4'b0000},  // R5 positive
        {1'b1, 2'd0, 4'b0110, 4'b0110},  // R1
        {1'b0, 2'd0, 4'b1001, 4'b1001},  // R1
        {1'b1, 2'd1, 4'b1001, 4'b0010},  // R6 left
        {1'b0, 2'd1, 4'b1001, 4'b1100}   // R6 right
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic d, input logic [1:0] a, input logic [3:0] x);
        @(negedge clk);
        dir  = d;
        amt  = a;
        opnd = x;
        #1;
    endtask

    function automatic logic [3:0] model(input logic d, input logic [1:0] a, input logic [3:0] x);
        if (d) return x << a;
        return 4'($signed(x) >>> a);
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [3:0] fillm;
        logic [3:0] rv;
        dir  = 1'b1;
        amt  = 2'd0;
        opnd = 4'b1010;
        #1;
        check("R1 initial pass-through", res, 4'b1010);

        foreach (VEC[i]) begin
            apply(VEC[i][10], VEC[i][9:8], VEC[i][7:4]);
            check("R1-R6 vector table", res, VEC[i][3:0]);
        end

        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < 4; a++) begin
                for (int x = 0; x < 16; x++) begin
                    apply(1'(d), 2'(a), 4'(x));
                    rv = res;
                    if (a == 0) check("R1 sweep", rv, 4'(x));
                    else if (d == 1) check("R2 sweep", rv, model(1'b1, 2'(a), 4'(x)));
                    else check("R4 sweep", rv, model(1'b0, 2'(a), 4'(x)));
                    if (d == 1) begin
                        fillm = 4'((1 << a) - 1);
                        check("R3 zero fill", rv & fillm, 4'b0000);
                    end else begin
                        fillm = 4'(~(4'hF >> a));
                        check("R5 sign fill", rv & fillm, x[3] ? fillm : 4'b0000);
                    end
                end
            end
        end

        // R6: same operand and amount, direction alone changes the result
        apply(1'b1, 2'd2, 4'b1101);
        check("R6 left", res, 4'b0100);
        apply(1'b0, 2'd2, 4'b1101);
        check("R6 right", res, 4'b1111);

        // R7: result follows inputs between clock edges
        @(posedge clk);
        #2;
        opnd = 4'b0111; dir = 1'b0; amt = 2'd1;
        #1;
        check("R7 no-clock response", res, 4'b0011);
        opnd = 4'b1000;
        #1;
        check("R7 no-clock response", res, 4'b1100);

        done = 1'b1;
        finish_run();
    end
endmodule